// File: doc/BRIEF.md
# Dual-Output PWM Slice with Run-Time Phase Nudging

This block is one pulse-width-modulation slice. One up-counter is shared by two outputs, and each output has its own compare threshold. A fractional divider in 12.4 fixed point turns the system clock into count-enable ticks. The counter runs in one of two modes:

- **Edge-aligned:** the counter runs from zero to a programmable top value and then wraps.
- **Phase-correct:** the counter rises to the top value and then falls back to zero.

The top value, the compare thresholds and the mode are shadowed. They are taken in only at the period boundary, so a running waveform never shows a partial period.

Two request inputs move the slice's phase by one count while it runs:

- **Advance** slips an extra count into a cycle that has no divider tick.
- **Retard** swallows the next real divider tick.

Each request has a busy output. It stays high until the adjustment has been applied, so a controller can poll it.

Top module: `pwm_slice`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `count` is 0, `dir_down` is 0, and `out_a`, `out_b`, `adv_busy` and `ret_busy` are all 0.
- R2: The divider keeps an accumulator. In each enabled cycle it adds 16 (1.0 in 12.4 format). When the sum reaches or passes the effective divider, a tick is produced and the effective divider is subtracted. The effective divider is `div_val`, except that any value below 16 counts as 16.
- R3: In edge-aligned mode (`phase_correct`=0), each step adds one to `count`. A step taken at or above the active top value returns `count` to 0.
- R4: In phase-correct mode, `count` climbs one per step up to the top value and then descends one per step to 0. `dir_down` is 1 while `count` sits strictly between 0 and top on the falling leg. With a top of 0, `count` stays at 0.
- R5: `out_a` is 1 exactly when the active A threshold is greater than `count`; `out_b` follows the same rule with the B threshold. A threshold of 0 keeps the output low, and a threshold of top+1 keeps it high, for the whole period.
- R6: The active top, thresholds and mode are loaded from the inputs only on a step that leaves `count` at 0 at a period boundary. After reset the active top is 0, so the first step loads them.
- R7: A pulse on `adv_req` sets `adv_busy`. The next enabled cycle without a divider tick adds one extra step and clears `adv_busy`. `count` never moves more than one step in any cycle.
- R8: A pulse on `ret_req` sets `ret_busy`. The next divider tick is swallowed and `ret_busy` clears. Without a tick, a pending retard never moves `count`.
- R9: While `en` is 0, neither `count` nor the accumulator changes, and a pending adjustment stays pending.
- R10: A request that arrives while the same adjustment is already pending merges into it and produces only one extra or missing step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Slice run enable |
| div_val | input | 16 | Divider, 12.4 unsigned fixed point |
| top_val | input | 16 | Period limit (shadowed) |
| cmp_a_val | input | 16 | Output A threshold (shadowed) |
| cmp_b_val | input | 16 | Output B threshold (shadowed) |
| phase_correct | input | 1 | 1 selects up/down counting (shadowed) |
| adv_req | input | 1 | Phase-advance request pulse |
| ret_req | input | 1 | Phase-retard request pulse |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |
| adv_busy | output | 1 | Advance pending |
| ret_busy | output | 1 | Retard pending |
| count | output | 16 | Current counter value |
| dir_down | output | 1 | Counter on its falling leg |

## Verification
The bench targets the following corner cases:

- **Divider of exactly 1.0 or below.** Every cycle then ticks, so an advance can never find a free slot and must stay busy. A design that double-steps, or that drops the request, shows a wrong `count` or a cleared `adv_busy`.
- **Retard requested while the slice is stopped.** A design that steps backward or clears busy early is caught.
- **Thresholds of 0 and top+1.** Off-by-one comparisons show up as stray pulses.
- **Phase-correct turnarounds with tiny top values.** A design that dwells twice at 0 or at top shows up in the period length.
- **Shadow registers.** Top, thresholds and mode are changed mid-period; a design that loads them early is caught.

// File: rtl/pwm_slice.sv
module pwm_slice #(
  parameter int W    = 16,
  parameter int FRAC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] div_val,
  input  logic [W-1:0] top_val,
  input  logic [W-1:0] cmp_a_val,
  input  logic [W-1:0] cmp_b_val,
  input  logic         phase_correct,
  input  logic         adv_req,
  input  logic         ret_req,
  output logic         out_a,
  output logic         out_b,
  output logic         adv_busy,
  output logic         ret_busy,
  output logic [W-1:0] count,
  output logic         dir_down
);

  localparam logic [W:0]   ONE  = (W+1)'(2**FRAC);
  localparam logic [W-1:0] UNIT = W'(1);

  logic [W:0]   acc, acc_sum, div_eff;
  logic         tick, adv_fire, step;
  logic [W-1:0] top_r, cmp_a_r, cmp_b_r;
  logic         pc_r;
  logic [W-1:0] nxt_cnt, dec_cnt;
  logic         nxt_dir, reload;

  assign div_eff  = ({1'b0, div_val} < ONE) ? ONE : {1'b0, div_val};
  assign acc_sum  = acc + ONE;
  assign tick     = en && (acc_sum >= div_eff);
  assign adv_fire = en && !tick && adv_busy;
  assign step     = (tick && !ret_busy) || adv_fire;
  assign dec_cnt  = count - UNIT;

  assign out_a = cmp_a_r > count;
  assign out_b = cmp_b_r > count;

  always_comb begin
    nxt_cnt = count;
    nxt_dir = dir_down;
    reload  = 1'b0;
    if (!pc_r) begin
      nxt_dir = 1'b0;
      if (count >= top_r) begin
        nxt_cnt = '0;
        reload  = 1'b1;
      end else begin
        nxt_cnt = count + UNIT;
      end
    end else if (!dir_down && count < top_r) begin
      nxt_cnt = count + UNIT;
    end else if (!dir_down && top_r == '0) begin
      nxt_cnt = '0;
      reload  = 1'b1;
    end else begin
      nxt_cnt = dec_cnt;
      if (dec_cnt == '0) begin
        nxt_dir = 1'b0;
        reload  = 1'b1;
      end else begin
        nxt_dir = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (en) begin
      acc <= tick ? acc_sum - div_eff : acc_sum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adv_busy <= 1'b0;
      ret_busy <= 1'b0;
    end else begin
      adv_busy <= adv_req | (adv_busy & ~adv_fire);
      ret_busy <= ret_req | (ret_busy & ~tick);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      dir_down <= 1'b0;
      top_r    <= '0;
      cmp_a_r  <= '0;
      cmp_b_r  <= '0;
      pc_r     <= 1'b0;
    end else if (step) begin
      count    <= nxt_cnt;
      dir_down <= nxt_dir;
      if (reload) begin
        top_r   <= top_val;
        cmp_a_r <= cmp_a_val;
        cmp_b_r <= cmp_b_val;
        pc_r    <= phase_correct;
      end
    end
  end

endmodule

// File: rtl/pwm_slice_chk.sv
module pwm_slice_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [W-1:0] count,
  input logic [W-1:0] top_q,
  input logic         pc_q,
  input logic         dir_down,
  input logic         adv_busy,
  input logic         ret_busy
);

  // R3
  count_le_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= top_q);

  // R7
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (count == $past(count) || count == $past(count) + W'(1) ||
               count == $past(count) - W'(1) || count == '0));

  // R9
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));

  // R9
  adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_busy && !en) |=> adv_busy);

  // R8
  ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_busy && !en) |=> ret_busy);

  // R4
  dir_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_down |-> pc_q);

  // R4
  dir_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_down |-> count != '0);

endmodule

bind pwm_slice pwm_slice_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .count(count), .top_q(top_r),
  .pc_q(pc_r), .dir_down(dir_down), .adv_busy(adv_busy), .ret_busy(ret_busy)
);

// File: tb/pwm_slice_bench.sv
module pwm_slice_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] div_val = 16'd16;
  logic [15:0] top_val = 16'd0;
  logic [15:0] cmp_a_val = 16'd0;
  logic [15:0] cmp_b_val = 16'd0;
  logic        phase_correct = 1'b0;
  logic        adv_req = 1'b0;
  logic        ret_req = 1'b0;
  logic        out_a, out_b, adv_busy, ret_busy, dir_down;
  logic [15:0] count;

  int total = 0;
  int bad = 0;

  int m_acc, m_cnt, m_top, m_ca, m_cb;
  bit m_dir, m_pc, m_ab, m_rb;

  pwm_slice u_pwm_slice (
    .clk(clk), .rst_n(rst_n), .en(en), .div_val(div_val), .top_val(top_val),
    .cmp_a_val(cmp_a_val), .cmp_b_val(cmp_b_val), .phase_correct(phase_correct),
    .adv_req(adv_req), .ret_req(ret_req), .out_a(out_a), .out_b(out_b),
    .adv_busy(adv_busy), .ret_busy(ret_busy), .count(count), .dir_down(dir_down)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_cnt = 0; m_top = 0; m_ca = 0; m_cb = 0;
    m_dir = 0; m_pc = 0; m_ab = 0; m_rb = 0;
  endtask

  function automatic bit limit_reached(int c, int t);
    return c >= t;
  endfunction

  task automatic take_shadow();
    m_top = top_val; m_ca = cmp_a_val; m_cb = cmp_b_val; m_pc = phase_correct;
  endtask

  task automatic model_edge();
    int dv, sum;
    bit tk, af, st;
    dv  = (div_val < 16) ? 16 : int'(div_val);
    sum = m_acc + 16;
    tk  = en && (sum >= dv);
    af  = en && !tk && m_ab;
    st  = (tk && !m_rb) || af;
    if (en) m_acc = tk ? sum - dv : sum;
    m_ab = adv_req || (m_ab && !af);
    m_rb = ret_req || (m_rb && !tk);
    if (st) begin
      if (!m_pc) begin
        if (limit_reached(m_cnt, m_top)) begin m_cnt = 0; take_shadow(); end
        else m_cnt++;
      end else if (!m_dir && m_cnt < m_top) begin
        m_cnt++;
      end else if (!m_dir && m_top == 0) begin
        take_shadow();
      end else begin
        m_cnt--;
        m_dir = (m_cnt != 0);
        if (m_cnt == 0) take_shadow();
      end
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "count", int'(count), m_cnt);
    chk("R4", "dir_down", int'(dir_down), int'(m_dir));
    chk("R5", "out_a", int'(out_a), int'(m_ca > m_cnt));
    chk("R5", "out_b", int'(out_b), int'(m_cb > m_cnt));
    chk("R7", "adv_busy", int'(adv_busy), int'(m_ab));
    chk("R8", "ret_busy", int'(ret_busy), int'(m_rb));
  endtask

  task automatic cyc(input string req);
    @(posedge clk);
    model_edge();
    #2;
    check_all(req);
    adv_req = 1'b0;
    ret_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_900_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    // R1: state held in reset
    chk("R1", "count in reset", int'(count), 0);
    chk("R1", "dir in reset", int'(dir_down), 0);
    chk("R1", "outs in reset", int'({out_a, out_b}), 0);
    chk("R1", "busy in reset", int'({adv_busy, ret_busy}), 0);
    rst_n = 1'b1;
    cyc("R1");

    // R5, R6: threshold 0 and top+1, divider 1.0
    en = 1'b1; div_val = 16'd16; top_val = 16'd9;
    cmp_a_val = 16'd0; cmp_b_val = 16'd10;
    for (int i = 0; i < 30; i++) begin
      cyc("R6");
      if (i > 1) begin
        chk("R5", "cmp 0 low", int'(out_a), 0);
        chk("R5", "cmp top+1 high", int'(out_b), 1);
      end
    end

    // R2: divider below 1.0 acts as 1.0; fractional 2.5
    div_val = 16'd5;
    for (int i = 0; i < 12; i++) cyc("R2");
    div_val = 16'd40; cmp_a_val = 16'd4;
    for (int i = 0; i < 60; i++) cyc("R2");

    // R7, R10: advance with a tick every cycle never fires
    div_val = 16'd16;
    adv_req = 1'b1;
    cyc("R7");
    for (int i = 0; i < 6; i++) begin
      if (i == 2) adv_req = 1'b1;
      cyc("R10");
    end
    chk("R7", "adv stays busy", int'(adv_busy), 1);
    div_val = 16'd48;
    for (int i = 0; i < 12; i++) cyc("R7");

    // R8, R9: retard while stopped
    en = 1'b0;
    ret_req = 1'b1;
    cyc("R8");
    for (int i = 0; i < 8; i++) cyc("R9");
    chk("R8", "retard held while stopped", int'(ret_busy), 1);
    en = 1'b1;
    for (int i = 0; i < 12; i++) cyc("R8");

    // R3, R4: phase-correct with small tops
    div_val = 16'd16; phase_correct = 1'b1; top_val = 16'd1; cmp_a_val = 16'd1;
    for (int i = 0; i < 24; i++) cyc("R4");
    top_val = 16'd0;
    for (int i = 0; i < 10; i++) cyc("R4");
    top_val = 16'd5; cmp_b_val = 16'd3;
    for (int i = 0; i < 40; i++) cyc("R4");
    phase_correct = 1'b0;
    for (int i = 0; i < 30; i++) cyc("R3");

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 39) == 0) begin
        top_val       = 16'($urandom_range(0, 12));
        cmp_a_val     = 16'($urandom_range(0, 14));
        cmp_b_val     = 16'($urandom_range(0, 14));
        phase_correct = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 59) == 0) div_val = 16'($urandom_range(0, 64));
      en      = ($urandom_range(0, 9) != 0);
      adv_req = ($urandom_range(0, 24) == 0);
      ret_req = ($urandom_range(0, 24) == 0);
      cyc("R6");
    end

    finish_run();
  end

endmodule